// File: doc/BRIEF.md
# Split-Transaction Bus Arbiter

This block is the central arbitration controller for a pipelined split-transaction interconnect whose address path and data path are arbitrated separately. Initiators post a request that carries a priority class, a transaction tag, an address, a read/write command and a length. The winner of each cycle is put on the address bus one cycle later and receives a single-cycle grant pulse. From then on its tag counts as outstanding. Many tags may be outstanding at the same time.

A target that has worked out its response reports this on a shared status channel by naming the tag. After that, the target may request the data bus with the same tag. The data arbiter rotates among targets and holds the data bus for every beat of the packet. When the last beat has gone, the tag becomes free and an initiator may use it again. A request that reuses a tag which is still outstanding waits until that tag is freed. The block moves no payload. It only counts the beats of each packet.

Top module: `stb_arbiter`

## Requirements
- R1: Address-bus arbitration serves the lowest class code first: class 0 (instruction) over 1 (data) over 2 (touch) over 3 (bulk transfer).
- R2: Among eligible requesters of one class, the grant rotates. The search starts just after the index that last won that class. After reset every class pointer sits at the highest initiator index.
- R3: A request sampled at a clock edge with no competitor wins at that edge. In the next cycle `a_gnt` is one-hot on the winner and the address bus shows its index, tag, address, command and length. The address bus carries at most one transaction per cycle.
- R4: A request whose tag is outstanding (address phase done, data phase not finished) is not granted. It stays pending until the data phase of that tag has ended.
- R5: A status report naming a tag that is not in the addressed state is ignored. Such a tag never becomes eligible for the data bus.
- R6: A data-bus request is granted only for a tag whose address phase and status report have both taken place.
- R7: The length field holds the byte count minus one (0..127 for 1..128 bytes). The number of data beats is the field's bits [6:4] plus one, which gives 1 to 8 beats.
- R8: Once granted, the data bus stays with the same target for all beats. `dbus_beat` counts 0,1,2.., and `dbus_last` marks the final beat. In the cycle after the final beat the bus is idle, and a new data grant follows no sooner than that.
- R9: Data-bus grants rotate among targets. The search starts after the target that last held the bus, and after reset the first target is preferred.
- R10: During reset all grants and both bus-valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_INIT | Per-initiator address request, held until granted |
| req_class | input | N_INIT*2 | Per-initiator priority class, 0 highest |
| req_id | input | N_INIT*ID_W | Per-initiator transaction tag |
| req_addr | input | N_INIT*ADDR_W | Per-initiator address |
| req_write | input | N_INIT | Per-initiator command, 1 write, 0 read |
| req_len | input | N_INIT*7 | Per-initiator byte count minus one |
| a_gnt | output | N_INIT | One-cycle address grant |
| abus_valid | output | 1 | Address bus carries a transaction |
| abus_src | output | clog2(N_INIT) | Index of the driving initiator |
| abus_id | output | ID_W | Tag on the address bus |
| abus_addr | output | ADDR_W | Address on the address bus |
| abus_write | output | 1 | Command on the address bus |
| abus_len | output | 7 | Length on the address bus |
| st_valid | input | 1 | Target status report strobe |
| st_id | input | ID_W | Tag of the status report |
| d_req | input | N_TGT | Per-target data-bus request, held until the last beat |
| d_id | input | N_TGT*ID_W | Per-target tag to return |
| d_gnt | output | N_TGT | Data-bus grant, held for the whole packet |
| dbus_valid | output | 1 | Data bus busy with a beat |
| dbus_id | output | ID_W | Tag driven on the data bus |
| dbus_beat | output | 3 | Beat index within the packet |
| dbus_last | output | 1 | Final beat of the packet |

## Verification
The hardest case to reach is a request stalled on a reused tag. To get there, the tag must first pass through the address phase, and the bench must then keep its status report and data phase back for a while. The bench does this by issuing a request with a tag from an earlier group that has not yet been released. It confirms that the request stays pending over many cycles. It then sends the status report and data request for that tag, and checks that the grant arrives only after the final beat. Rotation is tested by choosing the earlier winners so that a fixed-priority design would pick a different order than a rotating one. This is done for both the class pointers and the target pointer.

// File: rtl/stb_pkg.sv
// Shared types and constants for the split-transaction arbiter.
package stb_pkg;
    localparam int CLS_W   = 2;
    localparam int NUM_CLS = 4;
    localparam int LEN_W   = 7;
    localparam int BEAT_W  = 3;

    typedef enum logic [1:0] {
        ID_FREE = 2'd0,
        ID_ADDR = 2'd1,
        ID_STAT = 2'd2
    } id_state_e;

    // Beats minus one: 16 bytes per beat, length field is bytes minus one.
    function automatic logic [BEAT_W-1:0] len_to_beats_m1(input logic [LEN_W-1:0] len_m1);
        return len_m1[LEN_W-1:LEN_W-BEAT_W];
    endfunction
endpackage

// File: rtl/stb_rr_pick.sv
// Round-robin selector: picks the first set bit of mask strictly after ptr,
// wrapping around. Purely combinational; assumes ptr < N.
module stb_rr_pick #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from farthest to nearest so the nearest candidate wins.
    always_comb begin
        idx = '0;
        for (int k = N; k >= 1; k--) begin
            if (mask[(int'(ptr) + k) % N]) idx = IW'((int'(ptr) + k) % N);
        end
    end

    assign any = |mask;
endmodule

// File: rtl/stb_addr_arb.sv
// Address-bus arbiter: fixed priority across classes, rotating priority
// within a class with one pointer per class. Output is combinational; the
// caller registers the grant. Assumes elig already excludes stalled tags.
module stb_addr_arb
    import stb_pkg::*;
#(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         elig,
    input  logic [N*CLS_W-1:0]   cls,
    output logic                 win_valid,
    output logic [IW-1:0]        win_idx
);
    logic [NUM_CLS-1:0] cls_any;
    logic [IW-1:0]      cls_pick [NUM_CLS];
    logic [IW-1:0]      ptr_q    [NUM_CLS];
    logic [CLS_W-1:0]   win_cls;

    generate
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
            logic [N-1:0] cmask;
            // Requesters eligible in this class.
            always_comb begin
                for (int i = 0; i < N; i++)
                    cmask[i] = elig[i] && (cls[i*CLS_W +: CLS_W] == CLS_W'(c));
            end
            stb_rr_pick #(.N(N)) u_pick (
                .mask (cmask),
                .ptr  (ptr_q[c]),
                .any  (cls_any[c]),
                .idx  (cls_pick[c])
            );
        end
    endgenerate

    // Lowest class code with a candidate takes the cycle.
    always_comb begin
        win_valid = |cls_any;
        win_idx   = '0;
        win_cls   = '0;
        for (int c = NUM_CLS - 1; c >= 0; c--) begin
            if (cls_any[c]) begin
                win_idx = cls_pick[c];
                win_cls = CLS_W'(c);
            end
        end
    end

    // Advance the pointer of the winning class only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CLS; c++) ptr_q[c] <= IW'(N - 1);
        end else if (win_valid) begin
            ptr_q[win_cls] <= win_idx;
        end
    end
endmodule

// File: rtl/stb_id_table.sv
// Outstanding-tag table: one state entry and beat count per tag value.
// Set on address grant, advanced by a status report, freed after the last
// data beat. Answers lookups for every initiator and target in parallel.
module stb_id_table
    import stb_pkg::*;
#(
    parameter  int ID_W    = 8,
    parameter  int NQ_A    = 4,
    parameter  int NQ_D    = 2,
    localparam int NUM_IDS = 1 << ID_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [ID_W-1:0]        set_id,
    input  logic [BEAT_W-1:0]      set_bm1,
    input  logic                   stat_en,
    input  logic [ID_W-1:0]        stat_id,
    input  logic                   free_en,
    input  logic [ID_W-1:0]        free_id,
    input  logic [NQ_A*ID_W-1:0]   qa_id,
    output logic [NQ_A-1:0]        qa_busy,
    input  logic [NQ_D*ID_W-1:0]   qd_id,
    output logic [NQ_D-1:0]        qd_ready,
    output logic [NQ_D*BEAT_W-1:0] qd_bm1
);
    id_state_e          st_q  [NUM_IDS];
    logic [BEAT_W-1:0]  bm1_q [NUM_IDS];
    logic               stat_ok;

    // A status report only counts for a tag awaiting it.
    assign stat_ok = stat_en && (st_q[stat_id] == ID_ADDR);

    // Per-tag state transitions; the three writers never share a tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IDS; i++) begin
                st_q[i]  <= ID_FREE;
                bm1_q[i] <= '0;
            end
        end else begin
            if (set_en) begin
                st_q[set_id]  <= ID_ADDR;
                bm1_q[set_id] <= set_bm1;
            end
            if (stat_ok) st_q[stat_id] <= ID_STAT;
            if (free_en) st_q[free_id] <= ID_FREE;
        end
    end

    // Initiator-side lookup: is the tag in use?
    always_comb begin
        for (int q = 0; q < NQ_A; q++)
            qa_busy[q] = (st_q[qa_id[q*ID_W +: ID_W]] != ID_FREE);
    end

    // Target-side lookup: may the tag use the data bus, and for how long?
    always_comb begin
        for (int q = 0; q < NQ_D; q++) begin
            qd_ready[q]              = (st_q[qd_id[q*ID_W +: ID_W]] == ID_STAT);
            qd_bm1[q*BEAT_W +: BEAT_W] = bm1_q[qd_id[q*ID_W +: ID_W]];
        end
    end

    // R4
    set_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> st_q[set_id] == ID_FREE);

    // R6
    free_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> st_q[free_id] == ID_STAT);
endmodule

// File: rtl/stb_data_arb.sv
// Data-bus arbiter: rotates among targets whose tags are ready, then holds
// the bus for every beat of the packet. Arbitrates only while idle, so one
// idle cycle separates packets. Assumes a target keeps its request and tag
// steady until its last beat.
module stb_data_arb
    import stb_pkg::*;
#(
    parameter  int T    = 2,
    parameter  int ID_W = 8,
    localparam int TW   = (T > 1) ? $clog2(T) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [T-1:0]        d_req,
    input  logic [T*ID_W-1:0]   d_id,
    input  logic [T-1:0]        d_ready,
    input  logic [T*BEAT_W-1:0] d_bm1,
    output logic [T-1:0]        d_gnt,
    output logic                bus_valid,
    output logic [ID_W-1:0]     bus_id,
    output logic [BEAT_W-1:0]   bus_beat,
    output logic                bus_last,
    output logic                free_en,
    output logic [ID_W-1:0]     free_id
);
    logic              busy_q;
    logic [TW-1:0]     own_q;
    logic [TW-1:0]     ptr_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] tot_q;
    logic [ID_W-1:0]   id_q;
    logic              pick_any;
    logic [TW-1:0]     pick_idx;

    stb_rr_pick #(.N(T)) u_pick (
        .mask (d_req & d_ready),
        .ptr  (ptr_q),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    // Packet sequencer: capture a winner, count beats, release after last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            own_q  <= '0;
            ptr_q  <= TW'(T - 1);
            cnt_q  <= '0;
            tot_q  <= '0;
            id_q   <= '0;
        end else if (!busy_q) begin
            if (pick_any) begin
                busy_q <= 1'b1;
                own_q  <= pick_idx;
                ptr_q  <= pick_idx;
                cnt_q  <= '0;
                tot_q  <= d_bm1[int'(pick_idx)*BEAT_W +: BEAT_W];
                id_q   <= d_id[int'(pick_idx)*ID_W +: ID_W];
            end
        end else if (cnt_q == tot_q) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Grant vector follows the owner while busy.
    always_comb begin
        d_gnt = '0;
        if (busy_q) d_gnt[own_q] = 1'b1;
    end

    assign bus_valid = busy_q;
    assign bus_id    = id_q;
    assign bus_beat  = cnt_q;
    assign bus_last  = busy_q && (cnt_q == tot_q);
    assign free_en   = bus_last;
    assign free_id   = id_q;

    // R8
    hold_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_last) |=> bus_valid && $stable(d_gnt) && (bus_beat == $past(bus_beat) + 1'b1));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_last |=> !bus_valid);
endmodule

// File: rtl/stb_arbiter.sv
// Top of the split-transaction arbiter. Filters initiator requests against
// the outstanding-tag table, registers the address-bus winner, accepts
// status reports and runs the data-bus arbiter. Assumes initiators hold a
// request until granted and targets hold a data request until the last beat.
module stb_arbiter
    import stb_pkg::*;
#(
    parameter  int N_INIT = 4,
    parameter  int N_TGT  = 2,
    parameter  int ID_W   = 8,
    parameter  int ADDR_W = 32,
    localparam int SRC_W  = (N_INIT > 1) ? $clog2(N_INIT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_INIT-1:0]        req_valid,
    input  logic [N_INIT*CLS_W-1:0]  req_class,
    input  logic [N_INIT*ID_W-1:0]   req_id,
    input  logic [N_INIT*ADDR_W-1:0] req_addr,
    input  logic [N_INIT-1:0]        req_write,
    input  logic [N_INIT*LEN_W-1:0]  req_len,
    output logic [N_INIT-1:0]        a_gnt,
    output logic                     abus_valid,
    output logic [SRC_W-1:0]         abus_src,
    output logic [ID_W-1:0]          abus_id,
    output logic [ADDR_W-1:0]        abus_addr,
    output logic                     abus_write,
    output logic [LEN_W-1:0]         abus_len,
    input  logic                     st_valid,
    input  logic [ID_W-1:0]          st_id,
    input  logic [N_TGT-1:0]         d_req,
    input  logic [N_TGT*ID_W-1:0]    d_id,
    output logic [N_TGT-1:0]         d_gnt,
    output logic                     dbus_valid,
    output logic [ID_W-1:0]          dbus_id,
    output logic [BEAT_W-1:0]        dbus_beat,
    output logic                     dbus_last
);
    logic [N_INIT-1:0]        tag_busy;
    logic [N_INIT-1:0]        elig;
    logic                     win_valid;
    logic [SRC_W-1:0]         win_idx;
    logic [ID_W-1:0]          win_id;
    logic [LEN_W-1:0]         win_len;
    logic [N_TGT-1:0]         tgt_ready;
    logic [N_TGT*BEAT_W-1:0]  tgt_bm1;
    logic                     free_en;
    logic [ID_W-1:0]          free_id;

    // Requests on a tag still in flight are held back.
    assign elig    = req_valid & ~tag_busy;
    assign win_id  = req_id[int'(win_idx)*ID_W +: ID_W];
    assign win_len = req_len[int'(win_idx)*LEN_W +: LEN_W];

    stb_addr_arb #(.N(N_INIT)) u_aarb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .cls       (req_class),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    stb_id_table #(.ID_W(ID_W), .NQ_A(N_INIT), .NQ_D(N_TGT)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (win_valid),
        .set_id   (win_id),
        .set_bm1  (len_to_beats_m1(win_len)),
        .stat_en  (st_valid),
        .stat_id  (st_id),
        .free_en  (free_en),
        .free_id  (free_id),
        .qa_id    (req_id),
        .qa_busy  (tag_busy),
        .qd_id    (d_id),
        .qd_ready (tgt_ready),
        .qd_bm1   (tgt_bm1)
    );

    stb_data_arb #(.T(N_TGT), .ID_W(ID_W)) u_darb (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_req     (d_req),
        .d_id      (d_id),
        .d_ready   (tgt_ready),
        .d_bm1     (tgt_bm1),
        .d_gnt     (d_gnt),
        .bus_valid (dbus_valid),
        .bus_id    (dbus_id),
        .bus_beat  (dbus_beat),
        .bus_last  (dbus_last),
        .free_en   (free_en),
        .free_id   (free_id)
    );

    // Address bus stage: register the winner and pulse its grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_gnt      <= '0;
            abus_valid <= 1'b0;
            abus_src   <= '0;
            abus_id    <= '0;
            abus_addr  <= '0;
            abus_write <= 1'b0;
            abus_len   <= '0;
        end else begin
            a_gnt      <= win_valid ? (N_INIT'(1) << win_idx) : '0;
            abus_valid <= win_valid;
            abus_src   <= win_idx;
            abus_id    <= win_id;
            abus_addr  <= req_addr[int'(win_idx)*ADDR_W +: ADDR_W];
            abus_write <= req_write[win_idx];
            abus_len   <= win_len;
        end
    end

    // R3
    gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|a_gnt) |-> ((a_gnt & ~$past(req_valid)) == '0) && $onehot(a_gnt) && abus_valid);
endmodule

// File: tb/tb_stb_arbiter.sv
// Scoreboard bench: driver tasks queue expected address and data items,
// a negedge monitor pops and compares them as the buses show activity.
module tb_stb_arbiter;
    localparam int N  = 4;
    localparam int T  = 2;
    localparam int IW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_valid = '0;
    logic [N*2-1:0] req_class = '0;
    logic [N*IW-1:0] req_id = '0;
    logic [N*32-1:0] req_addr = '0;
    logic [N-1:0]   req_write = '0;
    logic [N*7-1:0] req_len = '0;
    logic [N-1:0]   a_gnt;
    logic           abus_valid;
    logic [1:0]     abus_src;
    logic [IW-1:0]  abus_id;
    logic [31:0]    abus_addr;
    logic           abus_write;
    logic [6:0]     abus_len;
    logic           st_valid = 1'b0;
    logic [IW-1:0]  st_id = '0;
    logic [T-1:0]   d_req = '0;
    logic [T*IW-1:0] d_id = '0;
    logic [T-1:0]   d_gnt;
    logic           dbus_valid;
    logic [IW-1:0]  dbus_id;
    logic [2:0]     dbus_beat;
    logic           dbus_last;

    stb_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_class(req_class), .req_id(req_id),
        .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
        .a_gnt(a_gnt), .abus_valid(abus_valid), .abus_src(abus_src),
        .abus_id(abus_id), .abus_addr(abus_addr), .abus_write(abus_write),
        .abus_len(abus_len), .st_valid(st_valid), .st_id(st_id),
        .d_req(d_req), .d_id(d_id), .d_gnt(d_gnt), .dbus_valid(dbus_valid),
        .dbus_id(dbus_id), .dbus_beat(dbus_beat), .dbus_last(dbus_last)
    );

    always #4 clk = ~clk;

    typedef struct { int src; int id; int len; string tag; } a_item_t;
    typedef struct { int id; int beats; int tgt; string tag; } d_item_t;

    a_item_t aq[$];
    d_item_t dq[$];
    a_item_t ea;
    d_item_t cur;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int beat_cnt = 0;
    int last_data_cyc = -10;
    int last_agnt_cyc = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int id);
        return 32'h1000_0000 + 32'(id * 64);
    endfunction

    task automatic exp_a(input int src, input int id, input int len, input string tag);
        a_item_t it;
        it.src = src; it.id = id; it.len = len; it.tag = tag;
        aq.push_back(it);
    endtask

    task automatic exp_d(input int id, input int beats, input int tgt, input string tag);
        d_item_t it;
        it.id = id; it.beats = beats; it.tgt = tgt; it.tag = tag;
        dq.push_back(it);
    endtask

    task automatic drv_a(input int i, input int cls, input int id, input int len);
        req_class[i*2 +: 2] = 2'(cls);
        req_id[i*IW +: IW]  = IW'(id);
        req_addr[i*32 +: 32] = addr_of(id);
        req_write[i]        = id[0];
        req_len[i*7 +: 7]   = 7'(len);
        req_valid[i]        = 1'b1;
    endtask

    task automatic drv_dreq(input int t, input int id);
        d_id[t*IW +: IW] = IW'(id);
        d_req[t] = 1'b1;
    endtask

    task automatic drv_status(input int id);
        @(negedge clk); #1;
        st_valid = 1'b1;
        st_id = IW'(id);
        @(negedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while ((aq.size() != 0 || dq.size() != 0 || req_valid != 0 || d_req != 0 || dbus_valid) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(n < 3000, tag, "drain timeout queued", aq.size() + dq.size(), 0);
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 60000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Monitor: scoreboard compare plus initiator and target agents.
    always @(negedge clk) begin
        if (rst_n) begin
            if (abus_valid) begin
                if (aq.size() == 0) begin
                    check(1'b0, "R4", "unexpected address grant src/id", abus_src * 256 + abus_id, 0);
                end else begin
                    ea = aq.pop_front();
                    check(abus_src == 2'(ea.src) && abus_id == IW'(ea.id) && abus_addr == addr_of(ea.id)
                          && abus_write == ea.id[0] && abus_len == 7'(ea.len)
                          && a_gnt == (N'(1) << ea.src), ea.tag, "address grant src/id",
                          abus_src * 256 + abus_id, ea.src * 256 + ea.id);
                end
                req_valid[abus_src] = 1'b0;
                last_agnt_cyc = cyc;
            end
            if (dbus_valid) begin
                if (dbus_beat == 3'd0) begin
                    if (dq.size() == 0) begin
                        check(1'b0, "R6", "unexpected data grant id", dbus_id, 0);
                        cur.id = dbus_id; cur.beats = 0; cur.tgt = 0; cur.tag = "R6";
                    end else begin
                        cur = dq.pop_front();
                        check(dbus_id == IW'(cur.id) && d_gnt == (T'(1) << cur.tgt), cur.tag,
                              "data grant target/id", d_gnt * 256 + dbus_id, (1 << cur.tgt) * 256 + cur.id);
                        check(cyc > last_data_cyc + 1, "R8", "idle gap before packet cycle",
                              cyc, last_data_cyc + 2);
                    end
                    beat_cnt = 0;
                end
                check(int'(dbus_beat) == beat_cnt && d_gnt == (T'(1) << cur.tgt) && dbus_id == IW'(cur.id),
                      "R8", "beat index", dbus_beat, beat_cnt);
                if (dbus_last) begin
                    check(beat_cnt + 1 == cur.beats, "R7", "beats in packet", beat_cnt + 1, cur.beats);
                    d_req[cur.tgt] = 1'b0;
                    last_data_cyc = cyc;
                end
                beat_cnt++;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet while reset is held
        check(a_gnt == 0 && !abus_valid && !dbus_valid && d_gnt == 0, "R10", "reset outputs",
              {a_gnt, abus_valid, dbus_valid, d_gnt}, 0);
        #1 rst_n = 1'b1;

        // R3: single request, grant visible one cycle later with all fields
        exp_a(1, 8'h30, 0, "R3");
        @(negedge clk); #1;
        drv_a(1, 3, 8'h30, 0);
        @(negedge clk);
        check(abus_valid && abus_src == 2'd1 && a_gnt == 4'b0010, "R3", "grant one cycle after request",
              {abus_valid, abus_src, a_gnt}, {1'b1, 2'd1, 4'b0010});
        wait_idle("R3");

        // R1: four classes at once, grant order follows class code
        exp_a(3, 8'h13, 15, "R1");
        exp_a(2, 8'h12, 16, "R1");
        exp_a(1, 8'h11, 127, "R1");
        exp_a(0, 8'h10, 0, "R1");
        @(negedge clk); #1;
        drv_a(0, 3, 8'h10, 0);
        drv_a(1, 2, 8'h11, 127);
        drv_a(2, 1, 8'h12, 16);
        drv_a(3, 0, 8'h13, 15);
        wait_idle("R1");

        // R2: class 2 pointer last won by initiator 1, so order is 2,0,1
        exp_a(2, 8'h22, 33, "R2");
        exp_a(0, 8'h20, 127, "R2");
        exp_a(1, 8'h21, 64, "R2");
        @(negedge clk); #1;
        drv_a(0, 2, 8'h20, 127);
        drv_a(1, 2, 8'h21, 64);
        drv_a(2, 2, 8'h22, 33);
        wait_idle("R2");

        // R4: reuse of outstanding tag 0x10 stalls until its data phase ends
        exp_a(0, 8'h10, 5, "R4");
        @(negedge clk); #1;
        drv_a(0, 3, 8'h10, 5);
        repeat (12) @(negedge clk);
        check(req_valid[0] == 1'b1 && aq.size() == 1, "R4", "stalled request still pending",
              req_valid[0], 1);
        exp_d(8'h10, 1, 0, "R4");
        drv_status(8'h10);
        @(negedge clk); #1;
        drv_dreq(0, 8'h10);
        wait_idle("R4");
        check(last_agnt_cyc > last_data_cyc, "R4", "regrant after last beat cycle",
              last_agnt_cyc, last_data_cyc + 1);

        // R6: data request without a status report is not granted
        @(negedge clk); #1;
        drv_dreq(1, 8'h11);
        repeat (10) @(negedge clk);
        check(d_req[1] == 1'b1 && !dbus_valid, "R6", "no grant before status", d_req[1], 1);
        exp_d(8'h11, 8, 1, "R7");
        drv_status(8'h11);
        wait_idle("R7");

        // R5: status for a tag never addressed is ignored
        drv_status(8'h55);
        @(negedge clk); #1;
        drv_dreq(1, 8'h55);
        repeat (10) @(negedge clk);
        check(d_req[1] == 1'b1 && !dbus_valid && d_gnt == 0, "R5", "ignored status gives no grant",
              d_gnt, 0);
        #1 d_req[1] = 1'b0;

        // R9: both targets, last holder was target 1, so target 0 first
        drv_status(8'h12);
        drv_status(8'h13);
        exp_d(8'h12, 2, 0, "R9");
        exp_d(8'h13, 1, 1, "R9");
        @(negedge clk); #1;
        drv_dreq(0, 8'h12);
        drv_dreq(1, 8'h13);
        wait_idle("R9");

        // R9: target 0 alone, then both, so target 1 comes first
        drv_status(8'h20);
        drv_status(8'h21);
        drv_status(8'h22);
        exp_d(8'h20, 8, 0, "R9");
        @(negedge clk); #1;
        drv_dreq(0, 8'h20);
        wait_idle("R9");
        exp_d(8'h22, 3, 1, "R9");
        exp_d(8'h21, 5, 0, "R8");
        @(negedge clk); #1;
        drv_dreq(0, 8'h21);
        drv_dreq(1, 8'h22);
        wait_idle("R8");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule